// File: doc/BRIEF.md
# Dual-Lane Carry Accumulate Unit

This execution unit serves a SIMD extension register file of sixteen 32-bit entries, where entry 0 always reads as zero. Each accepted instruction word names two destination and two source entries and updates up to two destinations in one clock edge. A control register holds a left carry flag in bit 31 and a right carry flag in bit 30.

The operate mode computes, for each lane, the sum or difference of the two source entries, as the lane's pattern bit selects. It writes each result to that lane's destination and records each lane's carry-out or borrow in its flag. The carry-accumulate mode adds a source entry plus the lane's stored flag onto the lane's destination and leaves both flags alone. A load port writes any nonzero entry and the control register directly, and an observation port reads any entry, so that state can be set up and inspected.

Top module: `dual_lane_acc_unit`

## Requirements
- R1: Instruction fields: first destination index bits 9:6, first source bits 13:10, second source bits 17:14, second destination bits 21:18, mode bits 23:22, pattern bits 25:24. The remaining bits are not decoded. Results are visible on the observation port after the clock edge at which the instruction is valid.
- R2: Mode values 2 and 3 change neither the register file nor the control register.
- R3: In mode 1 the first destination becomes its old value plus the first source plus control bit 31, modulo 2^32.
- R4: In mode 1 the second destination becomes its old value plus the second source plus control bit 30, modulo 2^32.
- R5: Mode 1 leaves control bits 31 and 30 unchanged, even when a lane overflows, and its result does not depend on the pattern field.
- R6: In mode 0 the first lane yields first source minus second source when pattern bit 1 is set, else their sum. The second lane does the same under pattern bit 0. All sources are read before any write.
- R7: In mode 0 control bit 31 takes the first lane's carry-out (add) or borrow (subtract, set when the minuend is below the subtrahend), and bit 30 takes the second lane's.
- R8: Entry 0 reads zero and is never written, including by the load port. When both destination indices are 0, the instruction changes nothing, flags included. When only one is 0, only the other lane's entry is written.
- R9: When both destination indices are equal and nonzero, the second lane's result is stored.
- R10: Reset (active low) clears every entry and the control register. No instruction changes control bits 29:0.
- R11: The load port writes one entry and the control register load replaces all 32 control bits. In the same cycle, an instruction's result and flags take precedence over the loaded value for the same entry or bit. Instruction sources and stored carries are read from the state before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | Instruction word is valid this cycle |
| instr | input | 32 | Instruction word |
| ld_en | input | 1 | Load port write enable |
| ld_idx | input | 4 | Load port entry index |
| ld_data | input | 32 | Load port data |
| cr_ld_en | input | 1 | Control register load enable |
| cr_ld_data | input | 32 | Control register load value |
| obs_idx | input | 4 | Observation port entry index |
| obs_data | output | 32 | Value of the observed entry |
| cr_q | output | 32 | Current control register value |

## Verification
The bench aims at the accumulate mode overflowing with a carry set. A design that lets that mode touch the flags would show a changed bit 31 or 30. It drives a borrow against a carry on the two lanes under mixed patterns. A swapped pattern bit or lane would show the wrong subtraction or flag. Identical destinations, a zero destination on one side or both, and zero-index sources catch a wrong write order and a write into entry 0. Invalid modes and a load in the same cycle as an instruction catch a design that acts on the reserved codes or reads its sources after the load.

// File: rtl/dla_pkg.sv
package dla_pkg;
    localparam int XLEN    = 32;
    localparam int IDX_W   = 4;

    localparam int POS_D1  = 6;
    localparam int POS_S1  = 10;
    localparam int POS_S2  = 14;
    localparam int POS_D2  = 18;
    localparam int POS_MD  = 22;
    localparam int POS_PAT = 24;

    typedef enum logic [1:0] {
        MD_OPERATE = 2'd0,
        MD_ACCUM   = 2'd1,
        MD_RSV2    = 2'd2,
        MD_RSV3    = 2'd3
    } mode_e;

    typedef struct packed {
        logic              act;
        logic              acc_mode;
        logic              flag_we;
        logic [1:0]        sub;
        logic [1:0]        we;
        logic [IDX_W-1:0]  dst_1;
        logic [IDX_W-1:0]  dst_2;
        logic [IDX_W-1:0]  src_1;
        logic [IDX_W-1:0]  src_2;
    } dec_t;
endpackage

// File: rtl/dla_decode.sv
module dla_decode
    import dla_pkg::*;
(
    input  logic        instr_valid,
    input  logic [31:0] instr,
    output dec_t        dec
);
    mode_e      mode;
    logic [1:0] pat;
    logic       unused_bits;

    assign unused_bits = ^{instr[31:26], instr[5:0]};

    always_comb begin
        mode         = mode_e'(instr[POS_MD +: 2]);
        pat          = instr[POS_PAT +: 2];
        dec          = '0;
        dec.dst_1    = instr[POS_D1 +: IDX_W];
        dec.dst_2    = instr[POS_D2 +: IDX_W];
        dec.src_1    = instr[POS_S1 +: IDX_W];
        dec.src_2    = instr[POS_S2 +: IDX_W];
        dec.act      = instr_valid
                     && (mode == MD_OPERATE || mode == MD_ACCUM)
                     && (dec.dst_1 != '0 || dec.dst_2 != '0);
        dec.acc_mode = (mode == MD_ACCUM);
        dec.flag_we  = dec.act && (mode == MD_OPERATE);
        dec.sub[0]   = pat[1];
        dec.sub[1]   = pat[0];
        dec.we[0]    = dec.act && (dec.dst_1 != '0);
        dec.we[1]    = dec.act && (dec.dst_2 != '0);
    end
endmodule

// File: rtl/dla_lane_alu.sv
module dla_lane_alu #(
    parameter int W = 32
) (
    input  logic         acc_mode,
    input  logic         sub,
    input  logic [W-1:0] dst_old,
    input  logic [W-1:0] src_x,
    input  logic [W-1:0] src_y,
    input  logic [W-1:0] acc_src,
    input  logic         cin,
    output logic [W-1:0] res,
    output logic         cout
);
    logic [W:0] wide;

    always_comb begin
        wide = '0;
        cout = 1'b0;
        if (acc_mode) begin
            wide = {1'b0, dst_old} + {1'b0, acc_src} + {{W{1'b0}}, cin};
        end else if (sub) begin
            wide = {1'b0, src_x} - {1'b0, src_y};
            cout = (src_x < src_y);
        end else begin
            wide = {1'b0, src_x} + {1'b0, src_y};
            cout = wide[W];
        end
        res = wide[W-1:0];
    end
endmodule

// File: rtl/dla_regfile.sv
module dla_regfile #(
    parameter int W = 32,
    parameter int N = 16,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [IW-1:0] ra_s1,
    input  logic [IW-1:0] ra_s2,
    input  logic [IW-1:0] ra_d1,
    input  logic [IW-1:0] ra_d2,
    input  logic [IW-1:0] ra_obs,
    output logic [W-1:0]  rd_s1,
    output logic [W-1:0]  rd_s2,
    output logic [W-1:0]  rd_d1,
    output logic [W-1:0]  rd_d2,
    output logic [W-1:0]  rd_obs,
    input  logic          ld_en,
    input  logic [IW-1:0] ld_idx,
    input  logic [W-1:0]  ld_data,
    input  logic          we_1,
    input  logic [IW-1:0] wa_1,
    input  logic [W-1:0]  wd_1,
    input  logic          we_2,
    input  logic [IW-1:0] wa_2,
    input  logic [W-1:0]  wd_2
);
    logic [W-1:0] rf_q [1:N-1];
    logic [W-1:0] rf_d [1:N-1];

    function automatic logic [W-1:0] rd(input logic [IW-1:0] a);
        logic [W-1:0] v;
        v = '0;
        for (int i = 1; i < N; i++) begin
            if (a == IW'(i)) v = rf_q[i];
        end
        return v;
    endfunction

    assign rd_s1  = rd(ra_s1);
    assign rd_s2  = rd(ra_s2);
    assign rd_d1  = rd(ra_d1);
    assign rd_d2  = rd(ra_d2);
    assign rd_obs = rd(ra_obs);

    always_comb begin
        for (int i = 1; i < N; i++) begin
            rf_d[i] = rf_q[i];
            if (ld_en && ld_idx == IW'(i)) rf_d[i] = ld_data;
            if (we_1 && wa_1 == IW'(i))    rf_d[i] = wd_1;
            if (we_2 && wa_2 == IW'(i))    rf_d[i] = wd_2;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 1; i < N; i++) rf_q[i] <= '0;
        end else begin
            for (int i = 1; i < N; i++) rf_q[i] <= rf_d[i];
        end
    end

    a_r8_lane1_not_zero_entry: assert property (@(posedge clk) disable iff (!rst_n)
        we_1 |-> wa_1 != '0);
    a_r8_lane2_not_zero_entry: assert property (@(posedge clk) disable iff (!rst_n)
        we_2 |-> wa_2 != '0);
endmodule

// File: rtl/dual_lane_acc_unit.sv
module dual_lane_acc_unit
    import dla_pkg::*;
#(
    parameter int DATA_W = XLEN,
    parameter int NREGS  = 16,
    localparam int IW    = $clog2(NREGS),
    localparam int CY_L  = DATA_W - 1,
    localparam int CY_R  = DATA_W - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_valid,
    input  logic [31:0]       instr,
    input  logic              ld_en,
    input  logic [IW-1:0]     ld_idx,
    input  logic [DATA_W-1:0] ld_data,
    input  logic              cr_ld_en,
    input  logic [DATA_W-1:0] cr_ld_data,
    input  logic [IW-1:0]     obs_idx,
    output logic [DATA_W-1:0] obs_data,
    output logic [DATA_W-1:0] cr_q
);
    typedef struct packed {
        logic [DATA_W-1:0] ctrl;
    } st_t;

    st_t  st_d, st_q;
    dec_t dec;

    logic [DATA_W-1:0] src_1_v, src_2_v;
    logic [DATA_W-1:0] dst_old [2];
    logic [DATA_W-1:0] acc_src [2];
    logic              cin     [2];
    logic [DATA_W-1:0] res     [2];
    logic              cout    [2];

    dla_decode u_dec (
        .instr_valid (instr_valid),
        .instr       (instr),
        .dec         (dec)
    );

    dla_regfile #(.W(DATA_W), .N(NREGS)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .ra_s1   (dec.src_1[IW-1:0]),
        .ra_s2   (dec.src_2[IW-1:0]),
        .ra_d1   (dec.dst_1[IW-1:0]),
        .ra_d2   (dec.dst_2[IW-1:0]),
        .ra_obs  (obs_idx),
        .rd_s1   (src_1_v),
        .rd_s2   (src_2_v),
        .rd_d1   (dst_old[0]),
        .rd_d2   (dst_old[1]),
        .rd_obs  (obs_data),
        .ld_en   (ld_en),
        .ld_idx  (ld_idx),
        .ld_data (ld_data),
        .we_1    (dec.we[0]),
        .wa_1    (dec.dst_1[IW-1:0]),
        .wd_1    (res[0]),
        .we_2    (dec.we[1]),
        .wa_2    (dec.dst_2[IW-1:0]),
        .wd_2    (res[1])
    );

    assign acc_src[0] = src_1_v;
    assign acc_src[1] = src_2_v;
    assign cin[0]     = st_q.ctrl[CY_L];
    assign cin[1]     = st_q.ctrl[CY_R];

    for (genvar g = 0; g < 2; g++) begin : g_lane
        dla_lane_alu #(.W(DATA_W)) u_alu (
            .acc_mode (dec.acc_mode),
            .sub      (dec.sub[g]),
            .dst_old  (dst_old[g]),
            .src_x    (src_1_v),
            .src_y    (src_2_v),
            .acc_src  (acc_src[g]),
            .cin      (cin[g]),
            .res      (res[g]),
            .cout     (cout[g])
        );
    end

    always_comb begin
        st_d = st_q;
        if (cr_ld_en) st_d.ctrl = cr_ld_data;
        if (dec.flag_we) begin
            st_d.ctrl[CY_L] = cout[0];
            st_d.ctrl[CY_R] = cout[1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cr_q = st_q.ctrl;

    a_r2_reserved_mode_keeps_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && instr[POS_MD +: 2] > 2'd1 && !cr_ld_en) |=> $stable(cr_q));
    a_r5_accum_keeps_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && instr[POS_MD +: 2] == 2'd1 && !cr_ld_en)
        |=> $stable(cr_q[CY_L:CY_R]));
    a_r10_low_ctrl_bits_kept: assert property (@(posedge clk) disable iff (!rst_n)
        !cr_ld_en |=> $stable(cr_q[CY_R-1:0]));
    a_r8_double_zero_noop: assert property (@(posedge clk) disable iff (!rst_n)
        (instr[POS_D1 +: IW] == '0 && instr[POS_D2 +: IW] == '0)
        |-> (dec.we == 2'b00 && !dec.flag_we));
endmodule

// File: tb/dual_lane_acc_unit_tb_top.sv
`timescale 1ns/1ps
module dual_lane_acc_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        instr_valid;
    logic [31:0] instr;
    logic        ld_en;
    logic [3:0]  ld_idx;
    logic [31:0] ld_data;
    logic        cr_ld_en;
    logic [31:0] cr_ld_data;
    logic [3:0]  obs_idx;
    logic [31:0] obs_data;
    logic [31:0] cr_q;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    int unsigned m_rf [16];
    int unsigned m_cr;

    always #4 clk = ~clk;

    dual_lane_acc_unit dut_i (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
        .ld_en(ld_en), .ld_idx(ld_idx), .ld_data(ld_data),
        .cr_ld_en(cr_ld_en), .cr_ld_data(cr_ld_data),
        .obs_idx(obs_idx), .obs_data(obs_data), .cr_q(cr_q)
    );

    function automatic logic [31:0] mk(input logic [1:0] pat, input logic [1:0] md,
                                       input logic [3:0] d2, input logic [3:0] s2,
                                       input logic [3:0] s1, input logic [3:0] d1);
        return {6'h0, pat, md, d2, s2, s1, d1, 6'h0};
    endfunction

    task automatic model(input logic iv, input logic [31:0] ins, input logic le,
                         input logic [3:0] li, input logic [31:0] ld,
                         input logic cle, input logic [31:0] cld);
        int unsigned b, c, oa, od, na, nd, crold;
        longint unsigned s;
        bit ca, cd;
        int d1, d2, md, pat;
        d1 = ins[9:6]; d2 = ins[21:18]; md = ins[23:22]; pat = ins[25:24];
        b = m_rf[ins[13:10]]; c = m_rf[ins[17:14]];
        oa = m_rf[d1]; od = m_rf[d2]; crold = m_cr;
        if (le && li != 0) m_rf[li] = ld;
        if (cle) m_cr = cld;
        if (iv && md < 2 && (d1 != 0 || d2 != 0)) begin
            if (md == 1) begin
                na = oa + b + ((crold >> 31) & 1);
                nd = od + c + ((crold >> 30) & 1);
            end else begin
                if (pat >= 2) begin na = b - c; ca = (b < c); end
                else begin s = longint'(b) + longint'(c); na = b + c; ca = s[32]; end
                if (pat % 2 == 1) begin nd = b - c; cd = (b < c); end
                else begin s = longint'(b) + longint'(c); nd = b + c; cd = s[32]; end
                m_cr[31] = ca;
                m_cr[30] = cd;
            end
            if (d1 != 0) m_rf[d1] = na;
            if (d2 != 0) m_rf[d2] = nd;
        end
    endtask

    task automatic compare_all(input string tag);
        if (done) return;
        checks++;
        if (cr_q !== m_cr) begin
            errors++;
            $display("FAIL %s ctrl actual %h expected %h", tag, cr_q, m_cr);
        end
        for (int i = 0; i < 16; i++) begin
            obs_idx = 4'(i);
            #1;
            checks++;
            if (obs_data !== m_rf[i]) begin
                errors++;
                $display("FAIL %s entry %0d actual %h expected %h", tag, i, obs_data, m_rf[i]);
            end
        end
    endtask

    task automatic step(input logic iv, input logic [31:0] ins, input logic le,
                        input logic [3:0] li, input logic [31:0] ld,
                        input logic cle, input logic [31:0] cld, input string tag);
        instr_valid = iv; instr = ins; ld_en = le; ld_idx = li; ld_data = ld;
        cr_ld_en = cle; cr_ld_data = cld;
        model(iv, ins, le, li, ld, cle, cld);
        @(posedge clk);
        #2;
        instr_valid = 0; instr = $urandom; ld_en = 0; cr_ld_en = 0;
        compare_all(tag);
    endtask

    task automatic op(input logic [31:0] ins, input string tag);
        step(1, ins, 0, 0, 0, 0, 0, tag);
    endtask

    task automatic load(input logic [3:0] li, input logic [31:0] ld, input string tag);
        step(0, 0, 1, li, ld, 0, 0, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual running expected finished");
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 0; instr_valid = 0; instr = 0; ld_en = 0; ld_idx = 0; ld_data = 0;
        cr_ld_en = 0; cr_ld_data = 0; obs_idx = 0;
        for (int i = 0; i < 16; i++) m_rf[i] = 0;
        m_cr = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        compare_all("R10 reset");

        // R11 load port, R8 load to entry 0 ignored
        load(1, 32'hFFFF_FFF0, "R11 load");
        load(2, 32'h0000_0020, "R11 load");
        load(3, 32'd5, "R11 load");
        load(4, 32'd7, "R11 load");
        load(5, 32'hFFFF_FFFF, "R11 load");
        load(0, 32'hDEAD_BEEF, "R8 entry0 load");

        // R1/R6/R7 add both lanes, carry out on both
        op(mk(2'b00, 2'd0, 4'd7, 4'd2, 4'd1, 4'd6), "R1/R6/R7 add");
        // R6/R7 lane1 subtract with borrow, lane2 add
        op(mk(2'b10, 2'd0, 4'd9, 4'd4, 4'd3, 4'd8), "R6/R7 sub-add");
        // R6/R7 lane2 subtract, no borrow
        op(mk(2'b01, 2'd0, 4'd11, 4'd3, 4'd4, 4'd10), "R6/R7 add-sub");

        // R10 low control bits survive operate mode
        step(0, 0, 0, 0, 0, 1, 32'h9234_5678, "R11 ctrl load");
        op(mk(2'b11, 2'd0, 4'd12, 4'd1, 4'd2, 4'd13), "R10/R7 low bits");

        // R3/R4/R5 accumulate with overflow, pattern ignored
        step(0, 0, 0, 0, 0, 1, 32'h8000_00AA, "R11 ctrl load");
        op(mk(2'b11, 2'd1, 4'd6, 4'd5, 4'd1, 4'd2), "R3/R4/R5 accum");
        step(0, 0, 0, 0, 0, 1, 32'h4000_0001, "R11 ctrl load");
        op(mk(2'b00, 2'd1, 4'd5, 4'd5, 4'd5, 4'd3), "R3/R4/R5 accum ovf");

        // R2 reserved modes
        op(mk(2'b00, 2'd2, 4'd7, 4'd2, 4'd1, 4'd6), "R2 mode2");
        op(mk(2'b11, 2'd3, 4'd7, 4'd2, 4'd1, 4'd6), "R2 mode3");

        // R8 both destinations zero: no flags either
        op(mk(2'b00, 2'd0, 4'd0, 4'd5, 4'd1, 4'd0), "R8 double zero");
        // R8 only second lane live
        op(mk(2'b00, 2'd1, 4'd4, 4'd3, 4'd1, 4'd0), "R8 lane2 only");
        op(mk(2'b00, 2'd0, 4'd0, 4'd3, 4'd1, 4'd14), "R8 lane1 only");
        // R8 zero-index sources read zero
        op(mk(2'b10, 2'd0, 4'd15, 4'd0, 4'd0, 4'd13), "R8 zero src");

        // R9 equal destinations
        op(mk(2'b10, 2'd0, 4'd7, 4'd4, 4'd3, 4'd7), "R9 equal op");
        op(mk(2'b00, 2'd1, 4'd8, 4'd2, 4'd1, 4'd8), "R9 equal accum");

        // R11 load and instruction in the same cycle
        step(1, mk(2'b00, 2'd0, 4'd9, 4'd9, 4'd1, 4'd9), 1, 4'd9, 32'h1111_1111,
             1, 32'h0F0F_0F0F, "R11 same cycle");
        step(1, mk(2'b00, 2'd1, 4'd10, 4'd10, 4'd10, 4'd0), 1, 4'd10, 32'h2222_2222,
             1, 32'hFFFF_FFFF, "R11 same cycle accum");

        // mixed traffic
        for (int n = 0; n < 300; n++) begin
            logic [31:0] w;
            logic le, cle;
            w = mk(2'($urandom), 2'($urandom_range(0, 3)), 4'($urandom), 4'($urandom),
                   4'($urandom), 4'($urandom));
            w[31:26] = 6'($urandom); w[5:0] = 6'($urandom);
            le  = ($urandom_range(0, 3) == 0);
            cle = ($urandom_range(0, 7) == 0);
            step(1, w, le, 4'($urandom), $urandom, cle, $urandom, "R1-mix R6/R3");
        end

        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule